// File: doc/BRIEF.md
# Interrupt Pending and Active Tracker

This block keeps two bits of state for every line in a bank of interrupt lines. The pending bit records that a line wants service. The active bit records that the line's handler is running. Each cycle the block picks the most urgent line that is pending, enabled and not already active. It raises a service request when that line may run. The line may run when no handler is active, or when its priority is strictly more urgent than the handler that was entered most recently.

The processor side gives two single-cycle strobes: one when it enters the handler of the offered line, and one when the current handler returns. Handlers may nest. A stack of line numbers remembers the entry order, so each return closes the handler that was entered last.

Each line is set to edge behaviour or held behaviour:
- An edge line latches a request once and can latch it again while its own handler runs, so it can be pending and active at the same time.
- A held line is forced pending on every cycle its request stays high.

Software can also set or clear single pending bits.

Top module: `irq_state_tracker`

## Requirements
- R1: A request that is high for a single clock edge sets the line's pending bit at that edge. The bit stays set after the request drops. An edge line (mode bit 0) latches on a low-to-high change of its request. A held line (mode bit 1) latches on every edge at which its request is high.
- R2: An entry strobe while the service request is high clears the pending bit of the offered line, sets its active bit and records it as the most recent entry. An entry strobe while the service request is low changes nothing.
- R3: A second request edge on an edge line that is already pending adds nothing. One handler entry clears the bit, and no further service is requested for that line.
- R4: A request edge on an edge line whose handler is active sets its pending bit again, so the line is both pending and active. An active line is never offered until its handler exits.
- R5: While a held line's request is high, its pending bit is set on every edge. This overrides handler entry and software clear on that edge.
- R6: The offered line is the one with the smallest priority value among lines that are pending, enabled and not active. A smaller value is more urgent. Lines with equal priority are resolved towards the lowest index. The priority of line i sits in bits [i*PW +: PW] of the priority input.
- R7: The service request is high only in two cases: no handler is active, or the offered line's priority value is strictly smaller than that of the most recently entered active line. Equal priority never preempts. The request also stays low when the nesting stack is full.
- R8: An exit strobe clears the active bit of the most recently entered line. An exit strobe with no active line changes nothing. When entry and exit strobes arrive on the same cycle, the exit is performed and the entry is ignored.
- R9: A per-line software set strobe sets the pending bit. A per-line software clear strobe clears it. When both act on the same line in the same cycle, the set wins.
- R10: A line whose enable bit is 0 still latches pending but is never offered for service.
- R11: After reset all pending and active bits are 0 and the service request is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqReq | input | NUM_LINES | Per-line request inputs |
| levelMode | input | NUM_LINES | 1 = held behaviour, 0 = edge behaviour |
| lineEnable | input | NUM_LINES | Per-line enable for selection |
| prioFlat | input | NUM_LINES*PRIO_W | Packed priorities, line i at [i*PRIO_W +: PRIO_W] |
| swSetPend | input | NUM_LINES | Software set-pending strobes |
| swClrPend | input | NUM_LINES | Software clear-pending strobes |
| enterStb | input | 1 | Handler entry for the offered line |
| exitStb | input | 1 | Return from the most recent handler |
| selId | output | $clog2(NUM_LINES) | Offered line number |
| svcReq | output | 1 | Offered line may be entered now |
| pendVec | output | NUM_LINES | Pending bits |
| actVec | output | NUM_LINES | Active bits |

## Verification
On every cycle the assertions check the following:
- The offered line is pending, enabled and inactive.
- Entry never pushes into a full stack.
- Exit never pops an empty one.
- The number of active bits equals the nesting depth.
- An entry leaves the entered line active and, unless a request re-asserts it, not pending.
- A held request keeps its line pending.

Only the bench scenarios can show the ordering behaviour. These are:
- tie resolution towards the lowest index;
- the refusal of equal-priority preemption;
- an edge line being re-latched during its own handler;
- a duplicate edge being absorbed;
- exits unwinding in last-in order.

// File: rtl/irq_trk_pkg.sv
package irq_trk_pkg;

  // Strobes from the arbitration control to the state datapath.
  typedef struct packed {
    logic doEnter;
    logic doExit;
  } trkStrobe_t;

endpackage

// File: rtl/irq_trk_state.sv
module irq_trk_state
  import irq_trk_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int DEPTH     = 8,
  localparam int IDW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int SPW = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqReq,
  input  logic [NUM_LINES-1:0] levelMode,
  input  logic [NUM_LINES-1:0] swSetPend,
  input  logic [NUM_LINES-1:0] swClrPend,
  input  trkStrobe_t           strb,
  input  logic [IDW-1:0]       enterId,
  output logic [NUM_LINES-1:0] pendVec,
  output logic [NUM_LINES-1:0] actVec,
  output logic [IDW-1:0]       topId,
  output logic                 stackEmpty,
  output logic                 stackFull
);

  logic [NUM_LINES-1:0] reqPrev;
  logic [NUM_LINES-1:0] setTerm;
  logic [NUM_LINES-1:0] clrTerm;
  logic [NUM_LINES-1:0] entryMask;
  logic [NUM_LINES-1:0] levelReqs;
  logic [NUM_LINES-1:0] pendNext;
  logic [IDW-1:0]       stackMem [DEPTH];
  logic [SPW-1:0]       sp;
  logic [AW-1:0]        topIdx;
  logic [AW-1:0]        pushIdx;

  // Held lines pend while high; edge lines pend on a rising request.
  assign levelReqs = levelMode & irqReq;
  assign setTerm   = levelReqs | (~levelMode & irqReq & ~reqPrev) | swSetPend;

  always_comb begin
    entryMask = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (strb.doEnter && (enterId == IDW'(i))) entryMask[i] = 1'b1;
    end
  end

  assign clrTerm  = swClrPend | entryMask;
  assign pendNext = setTerm | (pendVec & ~clrTerm);

  assign stackEmpty = (sp == '0);
  assign stackFull  = (sp == SPW'(DEPTH));
  assign topIdx     = AW'(sp - 1'b1);
  assign pushIdx    = AW'(sp);
  assign topId      = stackEmpty ? '0 : stackMem[topIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqPrev <= '0;
      pendVec <= '0;
      actVec  <= '0;
      sp      <= '0;
    end else begin
      reqPrev <= irqReq;
      pendVec <= pendNext;
      if (strb.doExit) begin
        sp             <= sp - 1'b1;
        actVec[topId]  <= 1'b0;
      end else if (strb.doEnter) begin
        sp             <= sp + 1'b1;
        actVec[enterId] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rstN && strb.doEnter && !strb.doExit) stackMem[pushIdx] <= enterId;
  end

  AST_PUSH_ROOM: assert property (@(posedge clk) disable iff (!rstN)
    strb.doEnter |-> (sp < SPW'(DEPTH)));  // R7
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    strb.doExit |-> (sp != '0));  // R8
  AST_ACT_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    $countones(actVec) == int'(sp));  // R8
  AST_ENTER_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doEnter && !strb.doExit) |=> actVec[$past(enterId)]);  // R2
  AST_ENTER_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doEnter && !setTerm[enterId]) |=> !pendVec[$past(enterId)]);  // R2
  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (|levelReqs) |=> ((pendVec & $past(levelReqs)) == $past(levelReqs)));  // R5

endmodule

// File: rtl/irq_trk_arb.sv
module irq_trk_arb
  import irq_trk_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int PRIO_W    = 3,
  localparam int IDW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_LINES-1:0]        pendVec,
  input  logic [NUM_LINES-1:0]        actVec,
  input  logic [NUM_LINES-1:0]        lineEnable,
  input  logic [NUM_LINES*PRIO_W-1:0] prioFlat,
  input  logic [IDW-1:0]              topId,
  input  logic                        stackEmpty,
  input  logic                        stackFull,
  input  logic                        enterStb,
  input  logic                        exitStb,
  output trkStrobe_t                  strb,
  output logic [IDW-1:0]              bestId,
  output logic                        svcReq
);

  logic [NUM_LINES-1:0] cand;
  logic                 found;
  logic [PRIO_W-1:0]    bestPrio;
  logic [PRIO_W-1:0]    topPrio;

  assign cand = pendVec & lineEnable & ~actVec;

  // Strict compare while scanning upward keeps the lowest index on ties.
  always_comb begin
    found    = 1'b0;
    bestPrio = '0;
    bestId   = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (cand[i] && (!found || (prioFlat[i*PRIO_W +: PRIO_W] < bestPrio))) begin
        found    = 1'b1;
        bestPrio = prioFlat[i*PRIO_W +: PRIO_W];
        bestId   = IDW'(i);
      end
    end
  end

  assign topPrio = prioFlat[int'(topId)*PRIO_W +: PRIO_W];
  assign svcReq  = found && !stackFull && (stackEmpty || (bestPrio < topPrio));

  assign strb.doExit  = exitStb && !stackEmpty;
  assign strb.doEnter = enterStb && svcReq && !exitStb;

  AST_SEL_ELIGIBLE: assert property (@(posedge clk) disable iff (!rstN)
    svcReq |-> (pendVec[bestId] && lineEnable[bestId] && !actVec[bestId]));  // R6

endmodule

// File: rtl/irq_state_tracker.sv
module irq_state_tracker
  import irq_trk_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int PRIO_W    = 3,
  localparam int IDW   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int DEPTH = 2 ** PRIO_W
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_LINES-1:0]        irqReq,
  input  logic [NUM_LINES-1:0]        levelMode,
  input  logic [NUM_LINES-1:0]        lineEnable,
  input  logic [NUM_LINES*PRIO_W-1:0] prioFlat,
  input  logic [NUM_LINES-1:0]        swSetPend,
  input  logic [NUM_LINES-1:0]        swClrPend,
  input  logic                        enterStb,
  input  logic                        exitStb,
  output logic [IDW-1:0]              selId,
  output logic                        svcReq,
  output logic [NUM_LINES-1:0]        pendVec,
  output logic [NUM_LINES-1:0]        actVec
);

  trkStrobe_t     strb;
  logic [IDW-1:0] topId;
  logic           stackEmpty;
  logic           stackFull;

  irq_trk_arb #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W)) uArb (
    .clk(clk), .rstN(rstN), .pendVec(pendVec), .actVec(actVec),
    .lineEnable(lineEnable), .prioFlat(prioFlat), .topId(topId),
    .stackEmpty(stackEmpty), .stackFull(stackFull), .enterStb(enterStb),
    .exitStb(exitStb), .strb(strb), .bestId(selId), .svcReq(svcReq)
  );

  irq_trk_state #(.NUM_LINES(NUM_LINES), .DEPTH(DEPTH)) uState (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .levelMode(levelMode),
    .swSetPend(swSetPend), .swClrPend(swClrPend), .strb(strb),
    .enterId(selId), .pendVec(pendVec), .actVec(actVec), .topId(topId),
    .stackEmpty(stackEmpty), .stackFull(stackFull)
  );

endmodule

// File: tb/sim_irq_state_tracker.sv
module sim_irq_state_tracker;

  localparam int N  = 32;
  localparam int PW = 3;

  typedef struct packed {
    logic [31:0] req;
    logic        en;
    logic        ex;
    logic [31:0] expPend;
    logic [31:0] expAct;
    logic        expSvc;
    logic [4:0]  expSel;
  } vec_t;

  // Priorities: line 3 and 5 -> 2, line 9 -> 1, line 12 -> 6, others -> 4.
  localparam vec_t TBL [11] = '{
    '{32'h0000_0020, 1'b0, 1'b0, 32'h0000_0020, 32'h0000_0000, 1'b1, 5'd5},  // R1 edge latch
    '{32'h0000_0028, 1'b0, 1'b0, 32'h0000_0028, 32'h0000_0000, 1'b1, 5'd3},  // R6 tie -> low index
    '{32'h0000_0000, 1'b1, 1'b0, 32'h0000_0020, 32'h0000_0008, 1'b0, 5'd5},  // R2 entry, R7 equal no preempt
    '{32'h0000_0200, 1'b0, 1'b0, 32'h0000_0220, 32'h0000_0008, 1'b1, 5'd9},  // R7 strictly more urgent
    '{32'h0000_0000, 1'b1, 1'b0, 32'h0000_0020, 32'h0000_0208, 1'b0, 5'd5},  // R2 nested entry
    '{32'h0000_0008, 1'b0, 1'b0, 32'h0000_0028, 32'h0000_0208, 1'b0, 5'd5},  // R4 pend while active
    '{32'h0000_0008, 1'b0, 1'b1, 32'h0000_0028, 32'h0000_0008, 1'b0, 5'd5},  // R8 pops line 9
    '{32'h0000_0000, 1'b0, 1'b1, 32'h0000_0028, 32'h0000_0000, 1'b1, 5'd3},  // R8 pops line 3, R4 offered
    '{32'h0000_1000, 1'b0, 1'b0, 32'h0000_1028, 32'h0000_0000, 1'b1, 5'd3},  // R5 held line pends
    '{32'h0000_1000, 1'b1, 1'b0, 32'h0000_1020, 32'h0000_0008, 1'b0, 5'd5},  // R6 priority over index
    '{32'h0000_1000, 1'b0, 1'b1, 32'h0000_1020, 32'h0000_0000, 1'b1, 5'd5}   // R8 unwind
  };

  logic          clk = 1'b0;
  logic          rstN;
  logic [N-1:0]  irqReq, levelMode, lineEnable, swSetPend, swClrPend;
  logic [N*PW-1:0] prioFlat;
  logic          enterStb, exitStb;
  logic [4:0]    selId;
  logic          svcReq;
  logic [N-1:0]  pendVec, actVec;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  irq_state_tracker #(.NUM_LINES(N), .PRIO_W(PW)) u0 (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .levelMode(levelMode),
    .lineEnable(lineEnable), .prioFlat(prioFlat), .swSetPend(swSetPend),
    .swClrPend(swClrPend), .enterStb(enterStb), .exitStb(exitStb),
    .selId(selId), .svcReq(svcReq), .pendVec(pendVec), .actVec(actVec)
  );

  task automatic chk(input bit ok, input string what, input logic [31:0] a, input logic [31:0] e);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", what, a, e);
    end
  endtask

  // Drive after a falling edge, let one rising edge pass, sample at the next falling edge.
  task automatic step(input logic [31:0] req, input logic en, input logic ex,
                      input logic [31:0] sSet, input logic [31:0] sClr);
    irqReq = req; enterStb = en; exitStb = ex; swSetPend = sSet; swClrPend = sClr;
    @(posedge clk);
    @(negedge clk);
    enterStb = 1'b0; exitStb = 1'b0; swSetPend = '0; swClrPend = '0;
  endtask

  initial begin
    #(8 * 100000);
    chk(1'b0, "watchdog expired", 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; irqReq = '0; enterStb = 1'b0; exitStb = 1'b0;
    swSetPend = '0; swClrPend = '0;
    levelMode = '0; levelMode[12] = 1'b1; levelMode[20] = 1'b1;
    lineEnable = '1; lineEnable[30] = 1'b0;
    for (int i = 0; i < N; i++) prioFlat[i*PW +: PW] = 3'd4;
    prioFlat[3*PW +: PW] = 3'd2; prioFlat[5*PW +: PW] = 3'd2;
    prioFlat[9*PW +: PW] = 3'd1; prioFlat[12*PW +: PW] = 3'd6;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(pendVec == 0 && actVec == 0, "R11 reset pend/act", {pendVec[15:0], actVec[15:0]}, 0);
    chk(svcReq == 1'b0, "R11 reset svcReq", 32'(svcReq), 0);

    for (int s = 0; s < 11; s++) begin
      step(TBL[s].req, TBL[s].en, TBL[s].ex, 0, 0);
      chk(pendVec == TBL[s].expPend, $sformatf("R1,R2,R4,R5 table step %0d pend", s), pendVec, TBL[s].expPend);
      chk(actVec == TBL[s].expAct, $sformatf("R2,R8 table step %0d act", s), actVec, TBL[s].expAct);
      chk(svcReq == TBL[s].expSvc, $sformatf("R6,R7 table step %0d svc", s), 32'(svcReq), 32'(TBL[s].expSvc));
      chk(selId == TBL[s].expSel, $sformatf("R6 table step %0d sel", s), 32'(selId), 32'(TBL[s].expSel));
    end
    step(0, 0, 0, 0, '1);
    chk(pendVec == 0, "R9 clear all", pendVec, 0);

    // R5: held request beats software clear and entry
    step(32'h1000, 0, 0, 0, 32'h1000);
    chk(pendVec == 32'h1000, "R5 held beats clear", pendVec, 32'h1000);
    step(32'h1000, 1, 0, 0, 0);
    chk(actVec == 32'h1000 && pendVec == 32'h1000, "R5 held pends while active",
        pendVec, 32'h1000);
    step(0, 0, 1, 0, 0);
    chk(actVec == 0 && pendVec == 32'h1000, "R5 latched after drop", pendVec, 32'h1000);
    step(0, 0, 0, 0, 32'h1000);
    chk(pendVec == 0, "R9 clear held line", pendVec, 0);

    // R1 and R3: single edge latch, duplicate edge absorbed
    step(32'h80, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    chk(pendVec == 32'h80, "R1 pulse stays latched", pendVec, 32'h80);
    step(32'h80, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    chk(pendVec == 0 && actVec == 32'h80, "R3 one entry clears duplicate", pendVec, 0);
    step(0, 0, 1, 0, 0);
    chk(actVec == 0 && svcReq == 1'b0, "R3 no second service", 32'(svcReq), 0);

    // R10: disabled line pends but is never offered
    step(32'h4000_0000, 0, 0, 0, 0);
    chk(pendVec == 32'h4000_0000 && svcReq == 1'b0, "R10 disabled line", 32'(svcReq), 0);
    step(0, 1, 0, 0, 32'h4000_0000);
    chk(actVec == 0 && pendVec == 0, "R2 entry ignored without svcReq", actVec, 0);

    // R9: set wins over clear on the same line
    step(0, 0, 0, 32'h200, 0);
    chk(pendVec == 32'h200 && selId == 5'd9 && svcReq, "R9 software set", pendVec, 32'h200);
    step(0, 0, 0, 32'h200, 32'h200);
    chk(pendVec == 32'h200, "R9 set beats clear", pendVec, 32'h200);

    // R8: empty exit, and simultaneous entry+exit
    step(0, 0, 1, 0, 0);
    chk(actVec == 0 && pendVec == 32'h200, "R8 exit with none active", pendVec, 32'h200);
    step(0, 1, 1, 0, 0);
    chk(actVec == 0 && pendVec == 32'h200, "R8 entry ignored with exit", actVec, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule